// File: doc/BRIEF.md
# Master-Mode Serial Frame Generator

This block turns the 16-bit output word of a converter into a serial frame when the converter supplies the serial clock itself. It watches the conversion busy flag. On its edges it loads a parallel result and shifts that result out most significant bit first. It produces three outputs: a divided serial clock, a data line and a frame-sync strobe. The strobe brackets the bits exactly and its active level can be selected.

Two read timings are offered. In read-after-convert, the falling edge of busy both captures the new result and starts its frame at once. In read-during-convert, every falling edge of busy parks the result in a shadow register. The next rising edge of busy, which marks the start of the following conversion, then sends that parked word while the converter works. The serial clock runs at half the system clock rate in the first mode and at a quarter of it in the second. The ratio is fixed for a frame when that frame starts. Chip select and read (both active low) gate the whole output. While either is high, nothing starts, and a frame in progress stops at once.

Top module: `ser_frame_gen`

## Requirements
- R1: While rst_n is low, sclk and sdata are 0 and fsync sits at its inactive level, which equals sync_inv.
- R2: With rd_mode = 0 (read-after-convert), the clock edge that sees busy fall starts a frame carrying the result present at that edge. The frame holds 16 bits, sent most significant bit first.
- R3: With rd_mode = 1 (read-during-convert), each fall of busy stores result in a shadow register. The next rise of busy starts a frame carrying that stored word.
- R4: The sclk period is 2 clk cycles (1 low, 1 high) in read-after-convert and 4 clk cycles (2 low, 2 high) in read-during-convert. The ratio is taken from rd_mode when the frame starts.
- R5: fsync is active for exactly the frame (16 sclk periods) and at no other time. With sync_inv = 0 the active level is 1; with sync_inv = 1 it is 0.
- R6: sdata changes only while sclk is low, together with the falling edge or at frame start. Each bit is stable for the low half-period before the rising edge and throughout the high phase.
- R7: Outside a frame, sclk and sdata are 0 and fsync is at its inactive level.
- R8: A start event is ignored unless cs_n and rd_n are both 0. If either goes high during a frame, the outputs return to idle at once and the frame does not resume.
- R9: A new result stored while a read-during-convert frame is running does not change the bits of that frame.
- R10: A start event that arrives while a frame is running is ignored. It neither restarts nor adds a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| busy | input | 1 | Conversion in progress flag from the converter core |
| result | input | 16 | Conversion result, valid when busy falls |
| rd_mode | input | 1 | 0 = read after convert, 1 = read during convert |
| sync_inv | input | 1 | 0 = fsync active high, 1 = fsync active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| sclk | output | 1 | Generated serial clock, idle low |
| sdata | output | 1 | Serial data, MSB first |
| fsync | output | 1 | Frame synchronization |

## Verification
Several rules are checked on every cycle: the quiet idle levels outside a frame, the immediate blanking when cs_n or rd_n is high, fsync being active whenever sclk is high, data held steady while sclk is high, and no high phase longer than the slower half-period. Other behaviour only shows up in the bench's scenarios: which word a frame carries in each read mode, the exact sclk period for each mode, the exact frame length and polarity, and that a shadow update or a second busy edge during a frame leaves the frame alone. The bench covers these by comparing recovered frames against a queue of expected words and periods.

// File: rtl/sfg_pkg.sv
// Shared types for the serial frame generator.
// Assumes: one read-mode select bit at the top-level boundary.
package sfg_pkg;
    typedef enum logic {
        RD_AFTER  = 1'b0,
        RD_DURING = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/sfg_edge_det.sv
// Busy edge detector: flags rising and falling edges of the busy input.
// Assumes: busy is synchronous to clk.
module sfg_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    output logic rise,
    output logic fall
);
    logic busy_q;

    // Remember the previous busy level.
    always_ff @(posedge clk) begin
        if (!rst_n) busy_q <= 1'b0;
        else        busy_q <= busy;
    end

    assign rise = busy & ~busy_q;
    assign fall = ~busy & busy_q;
endmodule

// File: rtl/sfg_phase_gen.sv
// Serial clock phase generator: toggles sclk every (lim+1) system clocks
// while run is high. sclk starts low on start and is held low when idle.
// Assumes: lim is held stable for the whole frame by the caller.
module sfg_phase_gen #(
    parameter int PW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          run,
    input  logic [PW-1:0] lim,
    output logic          sclk_q,
    output logic          fall_tick
);
    logic [PW-1:0] cnt;
    logic          wrap;

    assign wrap      = (cnt == lim);
    assign fall_tick = run & wrap & sclk_q;

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || start || !run) begin
            cnt    <= '0;
            sclk_q <= 1'b0;
        end else if (wrap) begin
            cnt    <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sfg_shifter.sv
// Result storage: a shadow word captured at end of conversion and a shift
// register that presents the frame MSB first.
// Assumes: start and shift are never high in the same cycle.
module sfg_shifter #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_shadow,
    input  logic [DW-1:0] din,
    input  logic          start,
    input  logic          use_direct,
    input  logic          shift,
    output logic          msb
);
    logic [DW-1:0] shadow;
    logic [DW-1:0] shreg;

    // Capture the finished result for a later read-during-convert frame.
    always_ff @(posedge clk) begin
        if (!rst_n)           shadow <= '0;
        else if (load_shadow) shadow <= din;
    end

    // Load the frame word, then move one bit per serial clock period.
    always_ff @(posedge clk) begin
        if (!rst_n)     shreg <= '0;
        else if (start) shreg <= use_direct ? din : shadow;
        else if (shift) shreg <= {shreg[DW-2:0], 1'b0};
    end

    assign msb = shreg[DW-1];
endmodule

// File: rtl/ser_frame_gen.sv
// Master-mode serial frame generator top. Starts a frame on busy fall
// (read after convert) or busy rise (read during convert), sends DW bits
// MSB first with a divided clock and a polarity-selectable frame sync.
// Assumes: all inputs synchronous to clk; DIV_* are even and at least 2.
module ser_frame_gen #(
    parameter int DW         = 16,
    parameter int DIV_AFTER  = 2,
    parameter int DIV_DURING = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          busy,
    input  logic [DW-1:0] result,
    input  logic          rd_mode,
    input  logic          sync_inv,
    input  logic          cs_n,
    input  logic          rd_n,
    output logic          sclk,
    output logic          sdata,
    output logic          fsync
);
    import sfg_pkg::*;

    localparam int HALF_AFT = DIV_AFTER / 2;
    localparam int HALF_DUR = DIV_DURING / 2;
    localparam int HMAX     = (HALF_DUR > HALF_AFT) ? HALF_DUR : HALF_AFT;
    localparam int PW       = $clog2(HMAX) + 1;
    localparam int BW       = $clog2(DW);

    rd_mode_e      mode;
    logic          b_rise, b_fall;
    logic          en, trig_aft, trig_dur, start;
    logic          active, act_o;
    logic [PW-1:0] lim_q;
    logic [BW-1:0] bit_cnt;
    logic          sclk_q, fall_tick, msb;

    assign mode     = rd_mode_e'(rd_mode);
    assign en       = ~cs_n & ~rd_n;
    assign trig_aft = b_fall & (mode == RD_AFTER);
    assign trig_dur = b_rise & (mode == RD_DURING);
    assign start    = en & ~active & (trig_aft | trig_dur);

    sfg_edge_det u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .busy  (busy),
        .rise  (b_rise),
        .fall  (b_fall)
    );

    // Frame activity flag: set on start, cleared on last bit or disable.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    active <= 1'b0;
        else if (start)                                active <= 1'b1;
        else if (!en)                                  active <= 1'b0;
        else if (fall_tick && bit_cnt == BW'(DW - 1))  active <= 1'b0;
    end

    // Bit counter and half-period limit latched per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            lim_q   <= '0;
        end else if (start) begin
            bit_cnt <= '0;
            lim_q   <= (mode == RD_DURING) ? PW'(HALF_DUR - 1) : PW'(HALF_AFT - 1);
        end else if (fall_tick) begin
            bit_cnt <= bit_cnt + 1'b1;
        end
    end

    sfg_phase_gen #(.PW(PW)) u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .run       (active),
        .lim       (lim_q),
        .sclk_q    (sclk_q),
        .fall_tick (fall_tick)
    );

    sfg_shifter #(.DW(DW)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_shadow (b_fall),
        .din         (result),
        .start       (start),
        .use_direct  (trig_aft),
        .shift       (fall_tick),
        .msb         (msb)
    );

    assign act_o = active & en;
    assign sclk  = sclk_q & act_o;
    assign sdata = msb & act_o;
    assign fsync = act_o ^ sync_inv;
endmodule

// File: rtl/sfg_chk.sv
// Protocol checker for ser_frame_gen, bound to every instance.
// Assumes: HMAX equals the longest serial clock half-period in clk cycles.
module sfg_chk #(
    parameter int HMAX = 2
) (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic rd_n,
    input logic sync_inv,
    input logic sclk,
    input logic sdata,
    input logic fsync
);
    int hi_run;

    // Count consecutive cycles with sclk high.
    always_ff @(posedge clk) begin
        if (!rst_n)    hi_run <= 0;
        else if (sclk) hi_run <= hi_run + 1;
        else           hi_run <= 0;
    end

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fsync == sync_inv) |-> (!sclk && !sdata));

    // R8
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n || rd_n) |-> (!sclk && fsync == sync_inv));

    // R5
    sync_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (fsync != sync_inv));

    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> $stable(sdata));

    // R4
    half_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sclk |-> (hi_run < HMAX));
endmodule

bind ser_frame_gen sfg_chk #(.HMAX(HMAX)) u_sfg_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .rd_n     (rd_n),
    .sync_inv (sync_inv),
    .sclk     (sclk),
    .sdata    (sdata),
    .fsync    (fsync)
);

// File: tb/tb_ser_frame_gen.sv
// Scoreboard bench: the driver pushes expected frames, the monitor rebuilds
// frames from the serial pins and compares word, period and length.
module tb_ser_frame_gen;
    typedef struct {
        logic [15:0] w;
        int          per;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        busy = 1'b0;
    logic [15:0] result = '0;
    logic        rd_mode = 1'b0;
    logic        sync_inv = 1'b0;
    logic        cs_n = 1'b0;
    logic        rd_n = 1'b0;
    logic        sclk, sdata, fsync;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    bit    mon_en = 1'b1;
    item_t q[$];
    logic [15:0] shadow_tb = '0;

    always #10 clk = ~clk;

    ser_frame_gen dut (
        .clk(clk), .rst_n(rst_n), .busy(busy), .result(result),
        .rd_mode(rd_mode), .sync_inv(sync_inv), .cs_n(cs_n), .rd_n(rd_n),
        .sclk(sclk), .sdata(sdata), .fsync(fsync)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    // One conversion: busy high for hi cycles, then falls with val.
    task automatic do_conv(input logic [15:0] val, input int hi, input bit push, input string req);
        item_t it;
        step();
        busy = 1'b1;
        if (push && rd_mode) begin
            it.w = shadow_tb; it.per = 4; it.req = req;
            q.push_back(it);
        end
        repeat (hi - 1) step();
        step();
        busy   = 1'b0;
        result = val;
        if (push && !rd_mode) begin
            it.w = val; it.per = 2; it.req = req;
            q.push_back(it);
        end
        shadow_tb = val;
    endtask

    task automatic idle_chk(input int n, input string req);
        bit ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sclk || sdata || fsync != sync_inv) ok = 1'b0;
        end
        chk(ok, req, {sclk, sdata, fsync}, {2'b00, sync_inv});
    endtask

    // Monitor: rebuild frames at sclk rising edges, sampled on negedges.
    logic        prev_sclk, prev_sdata;
    int          bits, gap, act_cnt, cur_per;
    string       cur_req;
    logic [15:0] word;
    always @(negedge clk) begin
        if (!mon_en || !rst_n) begin
            prev_sclk = 1'b0; bits = 0; gap = 0; act_cnt = 0; word = '0;
        end else begin
            gap++;
            if (fsync != sync_inv) act_cnt++;
            else if (act_cnt > 0) begin
                // R5: frame length equals 16 periods
                chk(act_cnt == 16 * cur_per, {cur_req, "/R5 len"}, act_cnt, 16 * cur_per);
                act_cnt = 0;
            end
            if (sclk && !prev_sclk) begin
                if (bits == 0) begin
                    if (q.size() == 0) begin
                        chk(1'b0, "R10 unexpected frame", 1, 0);
                        cur_per = 2; cur_req = "R10";
                    end else begin
                        cur_per = q[0].per; cur_req = q[0].req;
                    end
                end else begin
                    // R4: sclk period
                    chk(gap == cur_per, {cur_req, "/R4 period"}, gap, cur_per);
                end
                // R6: data stable before the rising edge
                chk(sdata == prev_sdata, {cur_req, "/R6 setup"}, sdata, prev_sdata);
                gap  = 0;
                word = {word[14:0], sdata};
                bits++;
                if (bits == 16) begin
                    if (q.size() > 0) begin
                        chk(word == q[0].w, {q[0].req, " word"}, word, q[0].w);
                        void'(q.pop_front());
                    end
                    bits = 0;
                end
            end
            prev_sclk  = sclk;
            prev_sdata = sdata;
        end
    end

    initial begin
        bit ok;
        // R1: reset levels for both polarities
        @(negedge clk);
        chk(!sclk && !sdata && fsync == 1'b0, "R1 reset", {sclk, sdata, fsync}, 0);
        step(); sync_inv = 1'b1;
        @(negedge clk);
        chk(!sclk && !sdata && fsync == 1'b1, "R1 reset inv", {sclk, sdata, fsync}, 1);
        step(); sync_inv = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
        idle_chk(4, "R7 idle after reset");

        // R2: read after convert frames
        do_conv(16'hA5C3, 6, 1, "R2");
        repeat (40) step();
        idle_chk(3, "R7 idle");
        do_conv(16'h8001, 3, 1, "R2");
        repeat (40) step();
        do_conv(16'hFFFF, 5, 1, "R2");
        repeat (40) step();
        // R5: active-low sync
        sync_inv = 1'b1;
        do_conv(16'h0F0F, 4, 1, "R5 inv");
        repeat (40) step();
        idle_chk(3, "R7 idle inv");
        sync_inv = 1'b0;

        // R3: read during convert sends the previous word
        rd_mode = 1'b1;
        do_conv(16'h1234, 70, 1, "R3");
        repeat (10) step();
        // R9: new result arrives mid-frame
        do_conv(16'hBEEF, 20, 1, "R9");
        repeat (70) step();
        // R10: second busy rise during a frame is ignored
        do_conv(16'h5A5A, 10, 1, "R10");
        repeat (5) step();
        do_conv(16'h3C3C, 10, 0, "R10");
        repeat (70) step();
        do_conv(16'h0001, 70, 1, "R3 latest");
        repeat (10) step();
        idle_chk(3, "R7 idle during");

        // R8: gating by rd_n and cs_n
        rd_mode = 1'b0;
        mon_en  = 1'b0;
        rd_n    = 1'b1;
        do_conv(16'h7777, 4, 0, "R8");
        idle_chk(40, "R8 rd_n high blocks");
        rd_n = 1'b0;
        do_conv(16'h1111, 4, 0, "R8");
        repeat (6) step();
        @(negedge clk);
        chk(fsync != sync_inv, "R8 frame running", fsync, ~sync_inv);
        step(); cs_n = 1'b1;
        @(negedge clk);
        chk(!sclk && fsync == sync_inv, "R8 abort", {sclk, fsync}, {1'b0, sync_inv});
        step(); cs_n = 1'b0;
        idle_chk(40, "R8 no resume");
        mon_en = 1'b1;
        repeat (2) step();
        do_conv(16'hC001, 4, 1, "R2 after abort");
        repeat (40) step();

        ok = (q.size() == 0);
        chk(ok, "R10 frame count", q.size(), 0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule